// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is an up-counting timer of eight bits that reloads itself. Each cycle it takes one count pulse from one of two sources. The first source is an instruction-rate enable that is already synchronous to the block clock. The second is a slow free-running oscillator level that is not synchronous to it. The oscillator level passes through a two-flop synchronizer, and a rising-edge detector turns it into a pulse one cycle wide. The selected pulse stream then goes through a binary prescaler, whose divide ratio is picked by a three-bit field. Each prescaled tick advances the counter by one.

When a tick arrives while the counter holds 0xFF, the counter takes the reload value in place of 0x00 and sets an interrupt request flag. The flag stays set until software pulses a clear input. Software reaches the block through one write port, and a select bit on that port picks either the reload register or the control word. The current count is always visible on a read port. A chip that needs two independent timers instantiates the block twice, and each copy has its own request line.

Top module: `tick_reload_timer`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, the count reads 0x00 and the interrupt request is low. Reset also clears the control word, which leaves the timer stopped.
- R2: Each prescaled tick raises the count by exactly one, except when the count is 0xFF. The count port shows the registered counter value.
- R3: The control word has a prescaler select in bits [2:0]. A value n gives one tick for every 2^(n+1) selected source pulses, from 2 up to 256. The prescaler restarts from zero on every control write and stays at zero while the timer is stopped.
- R4: A tick that finds the count at 0xFF loads the reload register into the counter, so the period is 256 minus the reload value in ticks.
- R5: The tick that wraps the counter sets the interrupt request. The request is visible on the same clock edge that loads the reload value.
- R6: The interrupt request stays high until a clear pulse is applied. A clear in a cycle without an overflow drops the request on the next edge. A clear in the same cycle as an overflow leaves the request set.
- R7: A reload write (select bit 0) made while the timer is stopped also loads the counter. A reload write made while the timer runs leaves the count unchanged and takes effect at the next wrap.
- R8: Control bit 3 picks the source. A value of 0 selects the instruction-rate enable. A value of 1 selects the rising edges of the synchronized oscillator input. The source that is not selected has no effect on the count.
- R9: Control bit 4 is the run enable. While it is 0, no tick occurs, and the count changes only through a reload write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = reload register, 1 = control word |
| wr_data | input | 8 | Write data |
| osc_in | input | 1 | Raw oscillator level, not synchronous to clk |
| sys_tick | input | 1 | Instruction-rate enable pulse, synchronous to clk |
| irq_clr | input | 1 | Clear pulse for the interrupt request |
| count_o | output | 8 | Current counter value |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The count shows a wrong prescaler phase or a wrong divide ratio as a step that comes too early or too late. That error appears within 2^(n+1) source pulses of the fault. A wrong source choice, or a run bit that is not honoured, shows as counting during windows where the count must hold still. A reload register that is lost or loaded too soon shows its wrong value at the first wrap, and the interrupt flag shows a wrong set or clear priority on the edge right after a clear. The directed cases place the clear on the overflow cycle, rewrite the reload register mid-run, and restart the prescaler with a control write, so each of these faults reaches the ports within a few ticks.

// File: rtl/prt_pkg.sv
`timescale 1ns/1ps
package prt_pkg;
  localparam int unsigned PSEL_W = 3;

  typedef enum logic {SEL_RELOAD = 1'b0, SEL_CTRL = 1'b1} wsel_e;
  typedef enum logic {SRC_SYS = 1'b0, SRC_OSC = 1'b1} src_e;

  // bit 4 run, bit 3 source, bits [2:0] prescaler select
  typedef struct packed {
    logic              run;
    src_e              src;
    logic [PSEL_W-1:0] psel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/prt_src_sync.sv
`timescale 1ns/1ps
module prt_src_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_in,
  input  logic          sys_tick,
  input  prt_pkg::src_e src,
  output logic          src_pulse
);
  // sync chain plus one extra flop that holds the previous synchronized level
  logic [STAGES:0] sh_q;
  logic            osc_edge;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], osc_in};
  end

  assign osc_edge  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign src_pulse = (src == prt_pkg::SRC_OSC) ? osc_edge : sys_tick;
endmodule

// File: rtl/prt_prescaler.sv
`timescale 1ns/1ps
module prt_prescaler #(
  parameter int unsigned PSEL_W = 3,
  localparam int unsigned DIV_W = 1 << PSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              src_pulse,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  // the low psel+1 bits take part in the terminal-count compare
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(psel));
  end

  assign tick = run & src_pulse & ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pre_q <= '0;
    else if (src_pulse)         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/prt_counter.sv
`timescale 1ns/1ps
module prt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             irq_q
);
  logic wrap;

  assign wrap = tick & (count_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (reload_we) reload_q <= wr_data;
      if (reload_we && !run) count_q <= wr_data;
      else if (wrap)         count_q <= reload_q;
      else if (tick)         count_q <= count_q + 1'b1;
      irq_q <= wrap | (irq_q & ~irq_clr);
    end
  end
endmodule

// File: rtl/tick_reload_timer.sv
`timescale 1ns/1ps
module tick_reload_timer #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             osc_in,
  input  logic             sys_tick,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  import prt_pkg::*;

  ctrl_t            ctrl_q;
  logic             ctrl_we;
  logic             reload_we;
  logic             src_pulse;
  logic             pre_tick;
  logic             run_w;
  logic [CNT_W-1:0] reload_q;

  assign ctrl_we   = wr_en & (wr_sel == SEL_CTRL);
  assign reload_we = wr_en & (wr_sel == SEL_RELOAD);
  assign run_w     = ctrl_q.run;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  prt_src_sync #(.STAGES(SYNC_STAGES)) u_src (
    .clk       (clk),
    .rst       (rst),
    .osc_in    (osc_in),
    .sys_tick  (sys_tick),
    .src       (ctrl_q.src),
    .src_pulse (src_pulse)
  );

  prt_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .restart   (ctrl_we),
    .src_pulse (src_pulse),
    .psel      (ctrl_q.psel),
    .tick      (pre_tick)
  );

  prt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .tick      (pre_tick),
    .reload_we (reload_we),
    .wr_data   (wr_data),
    .irq_clr   (irq_clr),
    .count_q   (count_o),
    .reload_q  (reload_q),
    .irq_q     (irq_o)
  );
endmodule

// File: rtl/prt_checker.sv
`timescale 1ns/1ps
module prt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             irq_clr,
  input logic             tick,
  input logic             run,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_o == '0 && !irq_o));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o != {CNT_W{1'b1}}) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o == {CNT_W{1'b1}}) |=> count_o == $past(reload_q));

  a_r5_wrap_sets_irq: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o == {CNT_W{1'b1}}) |=> irq_o);

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !(tick && count_o == {CNT_W{1'b1}})) |=> !irq_o);

  a_r9_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && wr_sel == 1'b0 && !run)) |=> $stable(count_o));
endmodule

bind tick_reload_timer prt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .irq_clr  (irq_clr),
  .tick     (pre_tick),
  .run      (run_w),
  .reload_q (reload_q),
  .count_o  (count_o),
  .irq_o    (irq_o)
);

// File: tb/tb_tick_reload_timer.sv
`timescale 1ns/1ps
module tb_tick_reload_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       osc_in = 1'b0;
  logic       sys_tick = 1'b0;
  logic       irq_clr = 1'b0;
  logic [7:0] count_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_reload_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .osc_in(osc_in), .sys_tick(sys_tick), .irq_clr(irq_clr),
    .count_o(count_o), .irq_o(irq_o)
  );

  // reload[47:40] psel[39:32] pulses[31:16] expected count[15:8] expected irq[7:0]
  localparam logic [47:0] VEC [0:6] = '{
    48'h00_00_000A_05_00,
    48'hF0_00_0028_F4_01,
    48'hFE_02_0018_FF_01,
    48'h10_07_00FF_10_00,
    48'h10_07_0100_11_00,
    48'hFF_01_000C_FF_01,
    48'h80_03_0040_84_00
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sys_tick = 1'b1;
      @(negedge clk); sys_tick = 1'b0;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic osc_periods(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (3) @(negedge clk); osc_in = 1'b1;
      repeat (3) @(negedge clk); osc_in = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", count_o, 8'h00);
    check("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count after reset", count_o, 8'h00);
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);

    // table: R2 R3 R4 R5 with instruction-rate source
    for (int i = 0; i < 7; i++) begin
      wr(1'b1, 8'h00);
      wr(1'b0, VEC[i][47:40]);
      clear_irq();
      check("R7 stopped reload loads count", count_o, VEC[i][47:40]);
      wr(1'b1, {3'b000, 1'b1, 1'b0, VEC[i][34:32]});
      pulses(int'(VEC[i][31:16]));
      check("R2 R3 R4 table count", count_o, VEC[i][15:8]);
      check("R5 table irq", {7'b0, irq_o}, VEC[i][7:0]);
    end

    // R9: stopped timer ignores pulses
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h33);
    check("R7 stopped load", count_o, 8'h33);
    pulses(6);
    check("R9 stopped count holds", count_o, 8'h33);

    // R7: reload write while running waits for the wrap
    clear_irq();
    wr(1'b0, 8'hFC);
    wr(1'b1, 8'h10);
    pulses(2);
    check("R2 running step", count_o, 8'hFD);
    wr(1'b0, 8'h20);
    check("R7 running reload leaves count", count_o, 8'hFD);
    pulses(4);
    check("R2 reach FF", count_o, 8'hFF);
    check("R5 no irq before wrap", {7'b0, irq_o}, 8'h00);
    pulses(2);
    check("R4 R7 wrap uses new reload", count_o, 8'h20);
    check("R5 irq on wrap", {7'b0, irq_o}, 8'h01);

    // R6: flag holds, then clear coinciding with overflow loses
    repeat (5) @(negedge clk);
    check("R6 irq holds without clear", {7'b0, irq_o}, 8'h01);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h10);
    pulses(1);
    @(negedge clk); sys_tick = 1'b1; irq_clr = 1'b1;
    @(negedge clk); sys_tick = 1'b0; irq_clr = 1'b0;
    check("R4 wrap on clear cycle", count_o, 8'hFF);
    check("R6 overflow beats clear", {7'b0, irq_o}, 8'h01);
    clear_irq();
    check("R6 clear drops irq", {7'b0, irq_o}, 8'h00);

    // R8: oscillator source, instruction tick held high and ignored
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h18);
    @(negedge clk); sys_tick = 1'b1;
    osc_periods(8);
    repeat (4) @(negedge clk);
    sys_tick = 1'b0;
    check("R8 osc edges counted", count_o, 8'h04);
    wr(1'b1, 8'h10);
    check("R8 control write keeps count", count_o, 8'h04);
    osc_periods(4);
    repeat (4) @(negedge clk);
    check("R8 osc ignored when sys selected", count_o, 8'h04);
    pulses(2);
    check("R8 sys source counts", count_o, 8'h05);

    // R3: control write restarts the prescaler phase
    pulses(1);
    wr(1'b1, 8'h10);
    pulses(1);
    check("R3 prescaler restarted", count_o, 8'h05);
    pulses(1);
    check("R3 tick after restart", count_o, 8'h06);

    // R1: reset mid-run clears count, flag and run enable
    pulses(2);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 count after late reset", count_o, 8'h00);
    pulses(4);
    check("R1 reset leaves timer stopped", count_o, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule